// File: doc/BRIEF.md
# Multi-word message send unit

This unit sits between a processor core and a network injection port. The core builds an outgoing message through a series of send commands. Each command carries one or two data words and an optional end mark. The unit turns every accepted word into one flit. The first word of a message is the destination node address. The second word names the operation to run at the receiver. Any later words are payload. Words leave in command order, and within a two-word command the first operand leaves first.

While a message is open, the unit holds its interrupt-enable output low. This keeps a handler from starting a second message in the middle of the first. The ending command clears the open state and raises interrupt-enable again. The priority given with the opening command tags every flit of the message. Injection takes one cycle from acceptance to the first flit and performs no translation of the destination.

When the network port stalls, the unit stalls the core through `cmd_ready` and loses no word. Two framing mistakes are reported on a one-cycle error pulse, and the offending command is discarded:
- an ending command issued while no message is open;
- a command flagged as carrying a new destination issued while a message is already open.

Top module: `msg_send_unit`

## Requirements
- R1: After reset, `cmd_ready` is 1, `net_valid` is 0, `irq_en` is 1 and `err` is 0.
- R2: The opcode is `cmd_op[0]` = two words and `cmd_op[1]` = ends the message (00 send one, 01 send two, 10 send one and end, 11 send two and end). A non-ending command accepted with no message open opens a message. Its first word becomes a flit with `net_head` = 1 and `net_tail` = 0, and `irq_en` reads 0 from the cycle after acceptance.
- R3: A two-word command emits `cmd_word0` as a flit before `cmd_word1`, and the flits of successive commands keep command order.
- R4: The last flit of an ending command has `net_tail` = 1. `irq_en` reads 1 from the cycle after that command is accepted.
- R5: Every flit of a message carries the `cmd_prio` of the command that opened it. The `cmd_prio` of later commands in the same message has no effect.
- R6: While `net_valid` is 1 and `net_ready` is 0, `net_valid`, `net_data`, `net_head`, `net_tail` and `net_prio` hold their values, and no word is lost or repeated.
- R7: `cmd_ready` is 0 while any flit of an earlier command is still waiting, and 1 once all have left.
- R8: An ending command accepted with no message open makes `err` 1 for exactly the next cycle. It produces no flit and leaves `irq_en` at 1.
- R9: A command with `cmd_dest` = 1 accepted while a message is open makes `err` 1 for one cycle and produces no flit. The message stays open with `irq_en` at 0, and later commands continue it.
- R10: A command that produces flits and is accepted at a clock edge presents its first flit with `net_valid` = 1 right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Send command present |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_op | input | 2 | Bit 0: two words; bit 1: ends the message |
| cmd_dest | input | 1 | First word is a new destination address |
| cmd_prio | input | PRIO_W | Message priority (used on the opening command) |
| cmd_word0 | input | WORD_W | First operand |
| cmd_word1 | input | WORD_W | Second operand (two-word commands) |
| net_valid | output | 1 | Flit available |
| net_ready | input | 1 | Network accepts the flit |
| net_data | output | WORD_W | Flit word |
| net_head | output | 1 | First flit of a message |
| net_tail | output | 1 | Last flit of a message |
| net_prio | output | PRIO_W | Priority of the message |
| irq_en | output | 1 | Interrupt enable, low while a message is open |
| err | output | 1 | One-cycle pulse on a discarded illegal command |

## Verification
Every result of an accepted command shows up right after the accepting edge: the first flit, the new `irq_en` level, the `err` pulse and the drop of `cmd_ready`. Inputs change at falling edges, so the bench checks these levels at the falling edge after acceptance. One cycle later it checks that `err` has dropped. Flits are logged by a monitor at every edge where `net_valid` and `net_ready` are both high, and each task compares that log with the expected order, framing bits and priority. During a stall the bench checks the held flit at each falling edge over several cycles.

// File: rtl/msu_pkg.sv
package msu_pkg;

  typedef enum logic [1:0] {
    OP_SEND1     = 2'b00,
    OP_SEND2     = 2'b01,
    OP_SEND1_END = 2'b10,
    OP_SEND2_END = 2'b11
  } msu_op_e;

  localparam int OP_BIT_TWO = 0;
  localparam int OP_BIT_END = 1;

  function automatic logic op_is_two(input logic [1:0] op);
    return op[OP_BIT_TWO];
  endfunction

  function automatic logic op_is_end(input logic [1:0] op);
    return op[OP_BIT_END];
  endfunction

endpackage

// File: rtl/msu_decode.sv
module msu_decode
  import msu_pkg::*;
(
  input  logic [1:0] cmd_op,
  input  logic       cmd_dest,
  input  logic       msg_open,
  output logic       two_words,
  output logic       ends,
  output logic       legal,
  output logic       opens
);

  always_comb begin
    two_words = op_is_two(cmd_op);
    ends      = op_is_end(cmd_op);
    // open message: a new destination is illegal
    // idle: an ending command is illegal
    if (msg_open) begin
      legal = !cmd_dest;
    end else begin
      legal = !ends;
    end
    opens = !msg_open && legal;
  end

endmodule

// File: rtl/msu_frame.sv
module msu_frame #(
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              legal,
  input  logic              ends,
  input  logic              opens,
  input  logic [PRIO_W-1:0] cmd_prio,
  output logic              msg_open_q,
  output logic              irq_en_q,
  output logic              err_q,
  output logic [PRIO_W-1:0] prio_sel
);

  logic [PRIO_W-1:0] prio_q;

  assign prio_sel = opens ? cmd_prio : prio_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_open_q <= 1'b0;
      irq_en_q   <= 1'b1;
      err_q      <= 1'b0;
      prio_q     <= '0;
    end else begin
      err_q <= fire && !legal;
      if (fire && legal) begin
        if (opens) begin
          prio_q <= cmd_prio;
        end
        if (ends) begin
          msg_open_q <= 1'b0;
          irq_en_q   <= 1'b1;
        end else begin
          msg_open_q <= 1'b1;
          irq_en_q   <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/msu_flit_buf.sv
module msu_flit_buf #(
  parameter int WORD_W = 32,
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              two_words,
  input  logic              ends,
  input  logic              head,
  input  logic [PRIO_W-1:0] prio,
  input  logic [WORD_W-1:0] word0,
  input  logic [WORD_W-1:0] word1,
  input  logic              net_ready,
  output logic              empty,
  output logic              net_valid,
  output logic [WORD_W-1:0] net_data,
  output logic              net_head,
  output logic              net_tail,
  output logic [PRIO_W-1:0] net_prio
);

  localparam int SLOTS = 2;
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] back_data_q;
  logic              back_tail_q;
  logic              pop;

  assign net_valid = (cnt_q != '0);
  assign empty     = (cnt_q == '0);
  assign pop       = net_valid && net_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      net_data    <= '0;
      net_head    <= 1'b0;
      net_tail    <= 1'b0;
      net_prio    <= '0;
      back_data_q <= '0;
      back_tail_q <= 1'b0;
    end else if (load) begin
      net_data    <= word0;
      net_head    <= head;
      net_tail    <= ends && !two_words;
      net_prio    <= prio;
      back_data_q <= word1;
      back_tail_q <= ends;
      cnt_q       <= two_words ? CNT_W'(2) : CNT_W'(1);
    end else if (pop) begin
      if (cnt_q == CNT_W'(2)) begin
        net_data <= back_data_q;
        net_head <= 1'b0;
        net_tail <= back_tail_q;
        cnt_q    <= CNT_W'(1);
      end else begin
        cnt_q <= '0;
      end
    end
  end

endmodule

// File: rtl/msg_send_unit.sv
module msg_send_unit #(
  parameter int WORD_W = 32,
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_dest,
  input  logic [PRIO_W-1:0] cmd_prio,
  input  logic [WORD_W-1:0] cmd_word0,
  input  logic [WORD_W-1:0] cmd_word1,
  output logic              net_valid,
  input  logic              net_ready,
  output logic [WORD_W-1:0] net_data,
  output logic              net_head,
  output logic              net_tail,
  output logic [PRIO_W-1:0] net_prio,
  output logic              irq_en,
  output logic              err
);

  logic              buf_empty;
  logic              fire;
  logic              two_words;
  logic              ends;
  logic              legal;
  logic              opens;
  logic              msg_open;
  logic [PRIO_W-1:0] prio_sel;

  assign cmd_ready = buf_empty;
  assign fire      = cmd_valid && cmd_ready;

  msu_decode u_decode (
    .cmd_op    (cmd_op),
    .cmd_dest  (cmd_dest),
    .msg_open  (msg_open),
    .two_words (two_words),
    .ends      (ends),
    .legal     (legal),
    .opens     (opens)
  );

  msu_frame #(.PRIO_W(PRIO_W)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .fire       (fire),
    .legal      (legal),
    .ends       (ends),
    .opens      (opens),
    .cmd_prio   (cmd_prio),
    .msg_open_q (msg_open),
    .irq_en_q   (irq_en),
    .err_q      (err),
    .prio_sel   (prio_sel)
  );

  msu_flit_buf #(.WORD_W(WORD_W), .PRIO_W(PRIO_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .load      (fire && legal),
    .two_words (two_words),
    .ends      (ends),
    .head      (opens),
    .prio      (prio_sel),
    .word0     (cmd_word0),
    .word1     (cmd_word1),
    .net_ready (net_ready),
    .empty     (buf_empty),
    .net_valid (net_valid),
    .net_data  (net_data),
    .net_head  (net_head),
    .net_tail  (net_tail),
    .net_prio  (net_prio)
  );

endmodule

// File: rtl/msu_checker.sv
module msu_checker #(
  parameter int WORD_W = 32,
  parameter int PRIO_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic              net_valid,
  input logic              net_ready,
  input logic [WORD_W-1:0] net_data,
  input logic              net_head,
  input logic              net_tail,
  input logic [PRIO_W-1:0] net_prio,
  input logic              irq_en,
  input logic              err
);

  // R6: held flit is stable under backpressure
  a_r6_hold_flit: assert property (@(posedge clk) disable iff (rst)
    (net_valid && !net_ready) |=> (net_valid && $stable(net_data) &&
      $stable(net_head) && $stable(net_tail) && $stable(net_prio)));

  // R7: no command taken while flits wait
  a_r7_ready_blocked: assert property (@(posedge clk) disable iff (rst)
    net_valid |-> !cmd_ready);

  // R4: interrupts come back only after an accepted ending command
  a_r4_irq_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_en) |-> $past(cmd_valid && cmd_ready && cmd_op[1]));

  // R2: interrupts drop only after an accepted non-ending command
  a_r2_irq_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_en) |-> $past(cmd_valid && cmd_ready && !cmd_op[1]));

  // R8: error follows an accepted command
  a_r8_err_cause: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(cmd_valid && cmd_ready));

  // R10: opening command shows a head flit the next cycle
  a_r10_head_next: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && irq_en && !cmd_op[1]) |=> (net_valid && net_head));

endmodule

bind msg_send_unit msu_checker #(.WORD_W(WORD_W), .PRIO_W(PRIO_W)) u_msu_checker (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .net_valid (net_valid),
  .net_ready (net_ready),
  .net_data  (net_data),
  .net_head  (net_head),
  .net_tail  (net_tail),
  .net_prio  (net_prio),
  .irq_en    (irq_en),
  .err       (err)
);

// File: tb/test_msg_send_unit.sv
module test_msg_send_unit;

  localparam int WORD_W = 32;
  localparam int PRIO_W = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [1:0]        cmd_op = 2'b00;
  logic              cmd_dest = 1'b0;
  logic [PRIO_W-1:0] cmd_prio = '0;
  logic [WORD_W-1:0] cmd_word0 = '0;
  logic [WORD_W-1:0] cmd_word1 = '0;
  logic              net_valid;
  logic              net_ready = 1'b1;
  logic [WORD_W-1:0] net_data;
  logic              net_head;
  logic              net_tail;
  logic [PRIO_W-1:0] net_prio;
  logic              irq_en;
  logic              err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [WORD_W-1:0] lg_data [64];
  logic              lg_head [64];
  logic              lg_tail [64];
  logic [PRIO_W-1:0] lg_prio [64];
  int                lg_n = 0;

  always #4 clk = ~clk;

  msg_send_unit #(.WORD_W(WORD_W), .PRIO_W(PRIO_W)) i_msg_send_unit (.*);

  always @(posedge clk) begin
    if (!rst && net_valid && net_ready && lg_n < 64) begin
      lg_data[lg_n] = net_data;
      lg_head[lg_n] = net_head;
      lg_tail[lg_n] = net_tail;
      lg_prio[lg_n] = net_prio;
      lg_n = lg_n + 1;
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic dest, input logic [PRIO_W-1:0] pr,
                      input logic [WORD_W-1:0] w0, input logic [WORD_W-1:0] w1);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_dest = dest; cmd_prio = pr;
    cmd_word0 = w0; cmd_word1 = w1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 50 && net_valid; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_flit(input string tag, input int k, input logic [WORD_W-1:0] d,
                          input logic h, input logic t, input logic [PRIO_W-1:0] p);
    chk({tag, " data"}, 64'(lg_data[k]), 64'(d));
    chk({tag, " head"}, 64'(lg_head[k]), 64'(h));
    chk({tag, " tail"}, 64'(lg_tail[k]), 64'(t));
    chk({tag, " prio"}, 64'(lg_prio[k]), 64'(p));
  endtask

  task automatic t_reset();
    chk("R1 cmd_ready", 64'(cmd_ready), 64'd1);
    chk("R1 net_valid", 64'(net_valid), 64'd0);
    chk("R1 irq_en", 64'(irq_en), 64'd1);
    chk("R1 err", 64'(err), 64'd0);
  endtask

  task automatic t_full_message();
    lg_n = 0;
    net_ready = 1'b1;
    send(2'b00, 1'b1, 2'd2, 32'h0000_0007, 32'h0);
    chk("R10 net_valid after accept", 64'(net_valid), 64'd1);
    chk("R2 head flit", 64'(net_head), 64'd1);
    chk("R2 irq_en low", 64'(irq_en), 64'd0);
    chk("R7 cmd_ready low", 64'(cmd_ready), 64'd0);
    send(2'b01, 1'b0, 2'd1, 32'hA0A0_0001, 32'hB0B0_0002);
    send(2'b10, 1'b0, 2'd3, 32'hC0C0_0003, 32'h0);
    chk("R4 irq_en high", 64'(irq_en), 64'd1);
    drain();
    chk("R3 flit count", 64'(lg_n), 64'd4);
    chk_flit("R2 flit0", 0, 32'h0000_0007, 1'b0 == 1'b0, 1'b0, 2'd2);
    chk_flit("R3 flit1", 1, 32'hA0A0_0001, 1'b0, 1'b0, 2'd2);
    chk_flit("R3 flit2", 2, 32'hB0B0_0002, 1'b0, 1'b0, 2'd2);
    chk_flit("R4 flit3", 3, 32'hC0C0_0003, 1'b0, 1'b1, 2'd2);
    chk("R5 prio of later cmd ignored", 64'(lg_prio[3]), 64'd2);
    chk("R7 cmd_ready after drain", 64'(cmd_ready), 64'd1);
  endtask

  task automatic t_backpressure();
    lg_n = 0;
    net_ready = 1'b0;
    send(2'b01, 1'b1, 2'd1, 32'h0000_0011, 32'h0000_0022);
    for (int i = 0; i < 4; i++) begin
      chk("R6 valid held", 64'(net_valid), 64'd1);
      chk("R6 data held", 64'(net_data), 64'h11);
      chk("R6 head held", 64'(net_head), 64'd1);
      chk("R6 prio held", 64'(net_prio), 64'd1);
      chk("R7 cmd_ready low stalled", 64'(cmd_ready), 64'd0);
      @(negedge clk);
    end
    net_ready = 1'b1;
    @(negedge clk);
    net_ready = 1'b0;
    @(negedge clk);
    chk("R6 second word held", 64'(net_data), 64'h22);
    chk("R6 tail held low", 64'(net_tail), 64'd0);
    @(negedge clk);
    net_ready = 1'b1;
    send(2'b10, 1'b0, 2'd0, 32'h0000_0033, 32'h0);
    drain();
    chk("R6 flit count", 64'(lg_n), 64'd3);
    chk_flit("R6 flit0", 0, 32'h11, 1'b1, 1'b0, 2'd1);
    chk_flit("R6 flit1", 1, 32'h22, 1'b0, 1'b0, 2'd1);
    chk_flit("R6 flit2", 2, 32'h33, 1'b0, 1'b1, 2'd1);
  endtask

  task automatic t_end_when_idle();
    lg_n = 0;
    net_ready = 1'b1;
    send(2'b11, 1'b0, 2'd3, 32'h0000_0044, 32'h0000_0055);
    chk("R8 err pulse", 64'(err), 64'd1);
    chk("R8 no flit", 64'(net_valid), 64'd0);
    chk("R8 irq_en stays", 64'(irq_en), 64'd1);
    @(negedge clk);
    chk("R8 err one cycle", 64'(err), 64'd0);
    chk("R8 no flit logged", 64'(lg_n), 64'd0);
  endtask

  task automatic t_dest_when_open();
    lg_n = 0;
    net_ready = 1'b1;
    send(2'b01, 1'b1, 2'd3, 32'h0000_0066, 32'h0000_0077);
    drain();
    send(2'b00, 1'b1, 2'd0, 32'h0000_0099, 32'h0);
    chk("R9 err pulse", 64'(err), 64'd1);
    chk("R9 no flit", 64'(net_valid), 64'd0);
    chk("R9 irq_en stays low", 64'(irq_en), 64'd0);
    @(negedge clk);
    chk("R9 err one cycle", 64'(err), 64'd0);
    send(2'b11, 1'b0, 2'd0, 32'h0000_0088, 32'h0000_00AA);
    chk("R9 irq_en high after end", 64'(irq_en), 64'd1);
    drain();
    chk("R9 flit count", 64'(lg_n), 64'd4);
    chk_flit("R9 flit0", 0, 32'h66, 1'b1, 1'b0, 2'd3);
    chk_flit("R9 flit2", 2, 32'h88, 1'b0, 1'b0, 2'd3);
    chk_flit("R9 flit3", 3, 32'hAA, 1'b0, 1'b1, 2'd3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_message();
    t_backpressure();
    t_end_when_idle();
    t_dest_when_open();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule